// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a slave on a two-wire serial bus (an I2C-style clock line and an open-drain data line). A host uses it to read and write a bank of 8-bit control registers. Both bus lines are sampled on a faster system clock through a synchronizer. Edges found on the synchronized lines mark the bit boundaries and the bus conditions. The block pulls the data line low through an output-enable and never drives it high.

A transfer opens with a START. A device address byte follows, and it must match a fixed prefix combined with a strap input. After a write-direction address, the next byte loads a register pointer. Any further bytes are written to successive registers. To read, the host sets the pointer in this way and then issues a repeated START and a read-direction address. The slave then returns register contents, advancing the pointer after each byte, until the host declines to acknowledge. The pointer wraps to zero after a parameterized last register.

Top module: `regbus_slave`

## Requirements
- R1: A falling data line while the clock line is high (START) aborts any transfer in progress, releases the data line and makes the next byte a device address. This applies mid-burst as well, so a repeated START can follow a write burst directly.
- R2: A rising data line while the clock line is high (STOP) returns the slave to idle and releases the data line. Bytes clocked after a STOP and before the next START are not acknowledged.
- R3: The device address byte is matched as {1,1,1,0,1, ~strap_i, strap_i, rw} from the most significant bit down, with rw=1 meaning read. The write/read codes are 0xEC/0xED with strap low and 0xEA/0xEB with strap high.
- R4: A device address that does not match gets no acknowledge, and the slave stays off the line until the next START.
- R5: During the ninth clock of a matched device address, a register address or a write data byte, the slave holds the data line low (acknowledge).
- R6: The byte following a write-direction device address loads the register pointer.
- R7: Each later byte of a write transfer is stored in the register at the pointer, and the pointer then advances.
- R8: The pointer advances from LAST_REG to 0x00. From any other value it advances by one, modulo 256.
- R9: After a repeated START with a read-direction address, the slave shifts out the register at the pointer, most significant bit first, one bit per clock low phase. The pointer advances after each byte.
- R10: When the host does not acknowledge a read byte, the slave releases the line and drives nothing until the next START. When the host does acknowledge, the slave sends the next register.
- R11: A write to an address above LAST_REG is acknowledged and changes no register. A read from such an address returns 0x00.
- R12: After reset all registers read as 0x00 and the data line is released.
- R13: The output-enable changes only after a clock-line falling edge, a START or a STOP is seen. It is never asserted outside acknowledge slots or read data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Address strap, selects the device address |
| sclk_i | input | 1 | Serial clock line as seen on the bus |
| sdata_i | input | 1 | Serial data line as seen on the bus |
| sdata_oe_o | output | 1 | When high, the data line is pulled low |

## Verification
Two events fall on the same edge: storing a write byte at the last register and wrapping the pointer to zero. The bench provokes this with a burst that starts at LAST_REG and continues past it. A read from LAST_REG then shows both the stored byte and the byte that landed at 0x00, and a checker property ties a commit at LAST_REG to a zero pointer in that same cycle. A repeated START is also placed right after a write acknowledge, so that the abort and the pointer persistence meet. In that case the read must return the register after the last one written.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] DEV_PREFIX = 5'b11101;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_REG, ST_REG_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } st_e;
endpackage

// File: rtl/regbus_line_sync.sv
module regbus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // conditions only count when the clock line was high on both samples
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/regbus_regfile.sv
module regbus_regfile
  import regbus_pkg::*;
#(
  parameter int LAST_REG = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [BYTE_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam int NREG = LAST_REG + 1;
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [BYTE_W-1:0] LAST_A = BYTE_W'(LAST_REG);

  logic [BYTE_W-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[i] <= '0;
      else if (wr_en_i && wr_addr_i == BYTE_W'(i)) mem[i] <= wr_data_i;
    end
  end

  assign rd_data_o = (rd_addr_i <= LAST_A) ? mem[rd_addr_i[IDX_W-1:0]] : '0;
endmodule

// File: rtl/regbus_engine.sv
module regbus_engine
  import regbus_pkg::*;
#(
  parameter int LAST_REG = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              oe_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [BYTE_W-1:0] ptr_o
);
  localparam logic [BYTE_W-1:0] LAST_A = BYTE_W'(LAST_REG);

  st_e               st;
  logic [BYTE_W-1:0] sr, tx;
  logic [3:0]        cnt;
  logic              rw, nack;
  logic [6:0]        dev_id;
  logic [BYTE_W-1:0] ptr_nxt;

  assign dev_id  = {DEV_PREFIX, ~strap_i, strap_i};
  assign ptr_nxt = (ptr_o == LAST_A) ? '0 : ptr_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; sr <= '0; tx <= '0; cnt <= '0;
      rw <= 1'b0; nack <= 1'b1; oe_o <= 1'b0;
      wr_en_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0; ptr_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        st <= ST_DEV; cnt <= '0; oe_o <= 1'b0;
      end else if (stop_i) begin
        st <= ST_IDLE; oe_o <= 1'b0;
      end else begin
        unique case (st)
          ST_DEV, ST_REG, ST_WR: begin
            if (scl_rise_i) begin
              sr  <= {sr[BYTE_W-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == 4'd8) begin
              if (st == ST_DEV) begin
                if (sr[7:1] == dev_id) begin
                  rw <= sr[0]; oe_o <= 1'b1; st <= ST_DEV_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_REG) begin
                ptr_o <= sr; oe_o <= 1'b1; st <= ST_REG_ACK;
              end else begin
                wr_en_o <= 1'b1; wr_addr_o <= ptr_o; wr_data_o <= sr;
                ptr_o <= ptr_nxt; oe_o <= 1'b1; st <= ST_WR_ACK;
              end
            end
          end
          ST_DEV_ACK: if (scl_fall_i) begin
            cnt <= '0;
            if (rw) begin
              tx <= rd_data_i; oe_o <= ~rd_data_i[7]; st <= ST_RD;
            end else begin
              oe_o <= 1'b0; st <= ST_REG;
            end
          end
          ST_REG_ACK, ST_WR_ACK: if (scl_fall_i) begin
            oe_o <= 1'b0; cnt <= '0; st <= ST_WR;
          end
          ST_RD: begin
            if (scl_rise_i) cnt <= cnt + 1'b1;
            else if (scl_fall_i) begin
              if (cnt == 4'd8) begin
                oe_o <= 1'b0; ptr_o <= ptr_nxt; st <= ST_RD_ACK;
              end else begin
                tx <= {tx[BYTE_W-2:0], 1'b0}; oe_o <= ~tx[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) nack <= sda_i;
            else if (scl_fall_i) begin
              if (nack) st <= ST_IDLE;
              else begin
                tx <= rd_data_i; oe_o <= ~rd_data_i[7]; cnt <= '0; st <= ST_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/regbus_slave.sv
module regbus_slave
  import regbus_pkg::*;
#(
  parameter int LAST_REG    = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic sdata_oe_o
);
  logic sda_s, scl_rise, scl_fall, start_w, stop_w, wr_en_w;
  logic [BYTE_W-1:0] wr_addr_w, wr_data_w, ptr_w, rd_data_w;

  regbus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i(sclk_i), .sda_i(sdata_i), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start_w), .stop_o(stop_w)
  );

  regbus_engine #(.LAST_REG(LAST_REG)) u_eng (
    .clk_i, .rst_ni, .strap_i, .sda_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start_w), .stop_i(stop_w),
    .rd_data_i(rd_data_w), .oe_o(sdata_oe_o), .wr_en_o(wr_en_w),
    .wr_addr_o(wr_addr_w), .wr_data_o(wr_data_w), .ptr_o(ptr_w)
  );

  regbus_regfile #(.LAST_REG(LAST_REG)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en_w), .wr_addr_i(wr_addr_w),
    .wr_data_i(wr_data_w), .rd_addr_i(ptr_w), .rd_data_o(rd_data_w)
  );
endmodule

// File: rtl/regbus_slave_chk.sv
module regbus_slave_chk #(
  parameter int LAST_REG = 31
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       stop_i,
  input logic       scl_fall_i,
  input logic       oe_i,
  input logic       wr_en_i,
  input logic [7:0] wr_addr_i,
  input logic [7:0] ptr_i
);
  localparam logic [7:0] LAST_A = 8'(LAST_REG);

  a_r1_start_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !oe_i);

  a_r2_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !oe_i);

  a_r13_oe_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_fall_i && !start_i && !stop_i) |=> $stable(oe_i));

  a_r5_ack_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> oe_i);

  a_r8_wrap_at_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == LAST_A) |-> ptr_i == 8'h00);
endmodule

bind regbus_slave regbus_slave_chk #(.LAST_REG(LAST_REG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_w), .stop_i(stop_w),
  .scl_fall_i(scl_fall), .oe_i(sdata_oe_o), .wr_en_i(wr_en_w),
  .wr_addr_i(wr_addr_w), .ptr_i(ptr_w)
);

// File: tb/tb_regbus_slave.sv
module tb_regbus_slave;
  localparam int LAST = 31;
  localparam int Q = 20;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic oe;
  wire  sda_line = sda_m & ~oe;

  int tests = 0, fails = 0, oe_viol = 0;
  bit drive_ok = 1'b0;
  logic [7:0] mdl [256];
  logic [7:0] wq [$];
  int mptr = 0;

  always #4 clk = ~clk;

  regbus_slave #(.LAST_REG(LAST)) dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap),
    .sclk_i(scl_m), .sdata_i(sda_line), .sdata_oe_o(oe)
  );

  // every clock: slave may only drive where the bench expects it to
  always @(negedge clk) if (rst_n && oe && !drive_ok) oe_viol++;

  function automatic int nextp(int p);
    return (p == LAST) ? 0 : (p + 1) % 256;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (Q) @(posedge clk);
  endtask

  task automatic bit_io(input logic d, output logic q);
    sda_m = d;
    half();
    scl_m = 1'b1;
    repeat (Q/2) @(posedge clk);
    @(negedge clk) q = sda_line;
    repeat (Q/2) @(posedge clk);
    scl_m = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic cond_start();
    sda_m = 1'b1; half(); scl_m = 1'b1; half();
    sda_m = 1'b0; half(); scl_m = 1'b0; repeat (2) @(posedge clk);
  endtask

  task automatic cond_stop();
    sda_m = 1'b0; half(); scl_m = 1'b1; half(); sda_m = 1'b1; half();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic q;
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) drive_ok = exp_ack;
      bit_io(b[i], q);
    end
    bit_io(1'b1, q);
    repeat (6) @(posedge clk);
    drive_ok = 1'b0;
    chk(q == !exp_ack, req, q, !exp_ack);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    logic q;
    drive_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, q);
      b[i] = q;
    end
    bit_io(mack ? 1'b0 : 1'b1, q);
    if (!mack) begin
      repeat (6) @(posedge clk);
      drive_ok = 1'b0;
    end
  endtask

  task automatic write_regs(input logic [7:0] devw, input logic [7:0] ra, input string req);
    cond_start();
    send_byte(devw, 1'b1, "R3 dev ack");
    send_byte(ra, 1'b1, "R5 reg ack");
    mptr = ra;
    foreach (wq[i]) begin
      send_byte(wq[i], 1'b1, req);
      if (mptr <= LAST) mdl[mptr] = wq[i];
      mptr = nextp(mptr);
    end
    cond_stop();
  endtask

  task automatic read_regs(input logic [7:0] devw, input logic [7:0] ra, input int n, input string req);
    logic [7:0] b;
    cond_start();
    send_byte(devw, 1'b1, "R3 dev ack");
    send_byte(ra, 1'b1, "R6 reg ack");
    mptr = ra;
    cond_start();
    send_byte(devw | 8'h01, 1'b1, "R9 read dev ack");
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(b == mdl[mptr], req, b, mdl[mptr]);
      mptr = nextp(mptr);
    end
    cond_stop();
  endtask

  initial begin
    logic [7:0] b;
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    repeat (5) @(posedge clk);
    @(negedge clk) chk(oe == 1'b0, "R12 line released in reset", oe, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk) chk(oe == 1'b0, "R12 line released after reset", oe, 0);

    read_regs(8'hEC, 8'h10, 1, "R12 reset value");

    // R6 R7 burst write, R9 R10 burst read ending in NACK
    wq = '{8'hA1, 8'hB2, 8'hC3};
    write_regs(8'hEC, 8'h03, "R7 write data ack");
    read_regs(8'hEC, 8'h03, 3, "R9 burst read");
    read_regs(8'hEC, 8'h04, 1, "R10 single read");

    // R4 mismatch: other strap code, then a wrong prefix
    cond_start();
    send_byte(8'hEA, 1'b0, "R4 wrong strap code");
    send_byte(8'h00, 1'b0, "R4 silent after mismatch");
    cond_stop();
    cond_start();
    send_byte(8'hEE, 1'b0, "R4 wrong prefix");
    cond_stop();

    // R2 bytes without START after STOP are ignored
    send_byte(8'hEC, 1'b0, "R2 no ack without start");
    send_byte(8'h05, 1'b0, "R2 still idle");

    // R8 wrap: commit at LAST and pointer to zero in one step
    wq = '{8'h5A, 8'h6B, 8'h7C};
    write_regs(8'hEC, 8'(LAST), "R8 write across wrap");
    read_regs(8'hEC, 8'(LAST), 3, "R8 read across wrap");

    // R11 beyond LAST_REG
    wq = '{8'h77, 8'h88};
    write_regs(8'hEC, 8'h40, "R11 write beyond acked");
    read_regs(8'hEC, 8'h40, 2, "R11 read beyond is zero");
    read_regs(8'hEC, 8'h00, 1, "R11 low regs untouched");

    // R1 restart right after a write ack; pointer persists
    wq = '{8'h99};
    write_regs(8'hEC, 8'h09, "R7 preset");
    cond_start();
    send_byte(8'hEC, 1'b1, "R1 dev ack");
    send_byte(8'h08, 1'b1, "R1 reg ack");
    send_byte(8'h11, 1'b1, "R1 data ack");
    mdl[8] = 8'h11;
    cond_start();
    send_byte(8'hED, 1'b1, "R1 read after restart");
    recv_byte(1'b0, b);
    chk(b == 8'h99, "R1 restart keeps pointer", b, 8'h99);
    cond_stop();
    read_regs(8'hEC, 8'h08, 1, "R7 restart-aborted burst kept byte");

    // R3 strap high selects the other code
    strap = 1'b1;
    repeat (4) @(posedge clk);
    wq = '{8'h42};
    write_regs(8'hEA, 8'h02, "R3 strap high write");
    read_regs(8'hEA, 8'h02, 1, "R3 strap high read");
    cond_start();
    send_byte(8'hEC, 1'b0, "R3 low code rejected with strap high");
    cond_stop();

    @(negedge clk) chk(oe == 1'b0, "R2 released after stop", oe, 0);
    chk(oe_viol == 0, "R13 drive only in ack/read slots", oe_viol, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule